// File: doc/BRIEF.md
# Dual Reference Switch Sequencer

The block feeds one of two reference clocks to a downstream phase-locked loop. It also decides when a change of reference actually takes place. A select input names the wanted reference. The block never moves to the new reference at the moment the select input toggles. Any toggle of the synchronized select value sends the controller from its normal state into a short-holdover state. In short holdover, phase-step compensation is turned off and the loop is expected to coast.

The new reference is committed only after the select value has stayed unchanged for a parameterized number of master-clock cycles. Any further toggle during that window restarts the wait. When the commit happens, the controller returns to normal. At that return, a manual control input decides whether phase-step compensation comes back on.

The block also synchronizes both references into the master-clock domain. It emits a one-cycle strobe on each falling edge of the active reference. The strobe is withheld while the controller is in short holdover.

Top module: `ref_switch_seq`

## Requirements
- R1: `ref_o` equals `ref0_i` while `active_sel_o` is 0 and equals `ref1_i` while `active_sel_o` is 1, with no register between them.
- R2: Each reference passes through SYNC_STAGES flops. `ref_fall_o` is high for exactly the one cycle in which the synchronized active reference reads 0 after reading 1 on the previous cycle. With the default gating, it stays low whenever `state_o` is not normal.
- R3: `sel_i` passes through SYNC_STAGES flops. Once warm-up is over, a change of the synchronized value while `state_o` is normal (code 2'b00) moves `state_o` to short holdover (code 2'b01) on the next clock edge and clears `tie_en_o` on the same edge. With two stages, this edge is the third clock edge after `sel_i` changes.
- R4: In short holdover, once the synchronized select has gone STABLE_CYCLES consecutive cycles without a change, the controller returns to normal. On that same edge, `active_sel_o` takes the synchronized select value. Short holdover with no further toggle lasts exactly STABLE_CYCLES cycles.
- R5: A change of the synchronized select during short holdover keeps the controller in short holdover. It leaves `active_sel_o` unchanged and restarts the stability count from zero.
- R6: On the edge that returns the controller to normal, `tie_en_o` takes the value of `tie_ctl_i` sampled at that edge.
- R7: `tie_en_o` stays low throughout short holdover, whatever `tie_ctl_i` does.
- R8: After reset, `state_o` is normal, `tie_en_o` is 1 and `hold_o` is 0. For the first SYNC_STAGES+1 edges, `active_sel_o` follows the synchronized select and no holdover is entered. As a result, a select level held through reset is the active reference once warm-up ends.
- R9: `hold_o` is high exactly while `state_o` is short holdover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Wanted reference (0 or 1), asynchronous |
| tie_ctl_i | input | 1 | Phase-step compensation wanted after a switch |
| ref0_i | input | 1 | Reference 0 |
| ref1_i | input | 1 | Reference 1 |
| ref_o | output | 1 | Active reference, combinational mux |
| ref_fall_o | output | 1 | One-cycle strobe on a falling edge of the active reference |
| active_sel_o | output | 1 | Index of the committed reference |
| state_o | output | 2 | 2'b00 normal, 2'b01 short holdover |
| tie_en_o | output | 1 | Phase-step compensation enable |
| hold_o | output | 1 | High in short holdover |

## Verification
A wrong stability count shows at the ports as a short-holdover window of the wrong length. `hold_o` and `state_o` would fall one or more cycles early or late, and the cycle-level comparison catches this on the first differing edge. A missed restart shows as an early commit of `active_sel_o`, or as a commit of a select value that was still moving. A wrong warm-up path shows right after reset, either as a spurious holdover or as the wrong active reference. An error in the synchronizer or the edge detector moves or drops `ref_fall_o` pulses, and a timing error changes which edge triggers holdover. Both are visible within a few cycles of the reference or select toggle.

// File: rtl/refsw_pkg.sv
package refsw_pkg;
   typedef enum logic [1:0] {
      RS_NORMAL     = 2'b00,
      RS_SHORT_HOLD = 2'b01
   } refsw_state_t;
endpackage

// File: rtl/refsw_sync.sv
// Multi-bit, multi-stage level synchronizer (bits are independent).
module refsw_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("refsw_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("refsw_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/refsw_timer.sv
// Stability window counter: expires after LIMIT running cycles without restart.
module refsw_timer #(
   parameter int LIMIT = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic expire
);
   localparam int CW = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("refsw_timer: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign expire = run && !restart && (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (run)     cnt <= expire ? '0 : cnt + 1'b1;
   end

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CW'(LIMIT)) else $error("count beyond window"); // R4
   AST_EXPIRE_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (cnt == '0)) else $error("count not cleared on expiry"); // R4
endmodule

// File: rtl/refsw_ctrl.sv
// Switch controller: warm-up, normal / short-holdover sequencing, TIE enable.
module refsw_ctrl
   import refsw_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int STABLE_CYCLES = 4096,
   parameter bit TIE_RST       = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sel_s,
   input  logic         tie_ctl,
   output refsw_state_t state_o,
   output logic         active_o,
   output logic         tie_en_o
);
   localparam int WU_MAX = SYNC_STAGES + 1;
   localparam int WU_W   = $clog2(WU_MAX + 1);

   logic [WU_W-1:0] wu_cnt;
   logic            primed;
   logic            sel_prev;
   logic            change;
   logic            in_hold;
   logic            expire;

   assign primed  = (wu_cnt == WU_W'(WU_MAX));
   assign change  = primed && (sel_s != sel_prev);
   assign in_hold = (state_o == RS_SHORT_HOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       wu_cnt <= '0;
      else if (!primed) wu_cnt <= wu_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_prev <= 1'b0;
      else        sel_prev <= sel_s;
   end

   refsw_timer #(.LIMIT(STABLE_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (in_hold),
      .restart (change),
      .expire  (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_o  <= RS_NORMAL;
         active_o <= 1'b0;
         tie_en_o <= TIE_RST;
      end else if (!primed) begin
         active_o <= sel_s;
      end else begin
         case (state_o)
            RS_NORMAL: begin
               if (change) begin
                  state_o  <= RS_SHORT_HOLD;
                  tie_en_o <= 1'b0;
               end
            end
            RS_SHORT_HOLD: begin
               if (expire) begin
                  state_o  <= RS_NORMAL;
                  active_o <= sel_s;
                  tie_en_o <= tie_ctl;
               end
            end
            default: state_o <= RS_NORMAL;
         endcase
      end
   end

   AST_ENTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == RS_NORMAL && change) |=> (in_hold && !tie_en_o)) else $error("no holdover entry"); // R3
   AST_COMMIT_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (in_hold ##1 state_o == RS_NORMAL) |-> (active_o == $past(sel_s))) else $error("wrong commit"); // R4
   AST_RESTART_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_hold && change) |=> (in_hold && $stable(active_o))) else $error("left holdover on toggle"); // R5
   AST_TIE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_hold ##1 state_o == RS_NORMAL) |-> (tie_en_o == $past(tie_ctl))) else $error("tie on return"); // R6
   AST_HOLD_TIE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      in_hold |-> !tie_en_o) else $error("tie on in holdover"); // R7
   AST_WARMUP_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
      !primed |-> (state_o == RS_NORMAL)) else $error("holdover in warm-up"); // R8
endmodule

// File: rtl/refsw_path.sv
// Reference datapath: mux, synchronization, falling-edge strobe.
module refsw_path #(
   parameter int SYNC_STAGES = 2,
   parameter bit FALL_GATE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref0,
   input  logic ref1,
   input  logic active,
   input  logic in_normal,
   output logic ref_o,
   output logic fall_o
);
   logic [1:0] rs;
   logic [1:0] rd;
   logic       fall_raw;

   assign ref_o = active ? ref1 : ref0;

   refsw_sync #(.STAGES(SYNC_STAGES), .W(2)) u_ref_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ref1, ref0}),
      .q     (rs)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd <= '0;
      else        rd <= rs;
   end

   assign fall_raw = rd[active] && !rs[active];

   generate
      if (FALL_GATE) begin : g_gated
         assign fall_o = fall_raw && in_normal;
         AST_FALL_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
            fall_o |-> in_normal) else $error("strobe in holdover"); // R2
      end else begin : g_open
         assign fall_o = fall_raw;
      end
   endgenerate

   AST_FALL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |-> !rs[active]) else $error("strobe without low level"); // R2
endmodule

// File: rtl/ref_switch_seq.sv
module ref_switch_seq
   import refsw_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int STABLE_CYCLES = 4096,
   parameter bit TIE_RST       = 1'b1,
   parameter bit FALL_GATE     = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel_i,
   input  logic       tie_ctl_i,
   input  logic       ref0_i,
   input  logic       ref1_i,
   output logic       ref_o,
   output logic       ref_fall_o,
   output logic       active_sel_o,
   output logic [1:0] state_o,
   output logic       tie_en_o,
   output logic       hold_o
);
   refsw_state_t state;
   logic         sel_s;

   refsw_sync #(.STAGES(SYNC_STAGES), .W(1)) u_sel_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sel_i),
      .q     (sel_s)
   );

   refsw_ctrl #(
      .SYNC_STAGES   (SYNC_STAGES),
      .STABLE_CYCLES (STABLE_CYCLES),
      .TIE_RST       (TIE_RST)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_s    (sel_s),
      .tie_ctl  (tie_ctl_i),
      .state_o  (state),
      .active_o (active_sel_o),
      .tie_en_o (tie_en_o)
   );

   refsw_path #(
      .SYNC_STAGES (SYNC_STAGES),
      .FALL_GATE   (FALL_GATE)
   ) u_path (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref0      (ref0_i),
      .ref1      (ref1_i),
      .active    (active_sel_o),
      .in_normal (state == RS_NORMAL),
      .ref_o     (ref_o),
      .fall_o    (ref_fall_o)
   );

   assign state_o = state;
   assign hold_o  = (state == RS_SHORT_HOLD);

   AST_HOLD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_o) |-> !tie_en_o) else $error("hold flag without tie off"); // R9
endmodule

// File: tb/tb_ref_switch_seq.sv
`timescale 1ns/1ps
module tb_ref_switch_seq;
   localparam int ST = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_i = 1'b1;
   logic tie_ctl_i = 1'b1;
   logic ref0_i = 1'b0;
   logic ref1_i = 1'b0;
   logic       ref_o, ref_fall_o, active_sel_o, tie_en_o, hold_o;
   logic [1:0] state_o;

   int total = 0;
   int bad = 0;
   bit done = 0;
   bit cmp_en = 0;

   always #2 clk = ~clk;

   ref_switch_seq #(.SYNC_STAGES(2), .STABLE_CYCLES(ST)) dut (
      .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .tie_ctl_i(tie_ctl_i),
      .ref0_i(ref0_i), .ref1_i(ref1_i), .ref_o(ref_o), .ref_fall_o(ref_fall_o),
      .active_sel_o(active_sel_o), .state_o(state_o), .tie_en_o(tie_en_o),
      .hold_o(hold_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit [1:0] m_sel, m_r0, m_r1;
   bit m_prev, m_active, m_tie, m_hold, m_rd0, m_rd1;
   int m_w, m_cnt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sel = 0; m_r0 = 0; m_r1 = 0; m_prev = 0; m_active = 0;
         m_tie = 1; m_hold = 0; m_rd0 = 0; m_rd1 = 0; m_w = 0; m_cnt = 0;
      end else begin
         bit primed, ch;
         primed = (m_w == 3);
         ch = primed && (m_sel[1] != m_prev);
         if (!primed) begin
            m_active = m_sel[1];
            m_w++;
         end else if (!m_hold) begin
            if (ch) begin m_hold = 1; m_tie = 0; m_cnt = 0; end
         end else begin
            if (ch) m_cnt = 0;
            else if (m_cnt == ST - 1) begin
               m_hold = 0; m_active = m_sel[1]; m_tie = tie_ctl_i; m_cnt = 0;
            end else m_cnt++;
         end
         m_prev = m_sel[1];
         m_rd0 = m_r0[1];
         m_rd1 = m_r1[1];
         m_sel = {m_sel[0], sel_i};
         m_r0 = {m_r0[0], ref0_i};
         m_r1 = {m_r1[0], ref1_i};
      end
   end

   // per-cycle comparison, away from both clock edges
   always @(negedge clk) begin
      #1;
      if (cmp_en) begin
         bit efall;
         efall = !m_hold && (m_active ? (m_rd1 && !m_r1[1]) : (m_rd0 && !m_r0[1]));
         chk("R1 ref_o", ref_o, m_active ? ref1_i : ref0_i);
         chk("R2 ref_fall_o", ref_fall_o, efall);
         chk("R3 state_o", state_o, m_hold ? 1 : 0);
         chk("R4 active_sel_o", active_sel_o, m_active);
         chk("R6 tie_en_o", tie_en_o, m_tie);
         chk("R9 hold_o", hold_o, m_hold);
      end
   end

   // background reference toggling
   initial begin
      int k = 0;
      forever begin
         @(negedge clk);
         k++;
         if (k % 3 == 0) ref0_i = ~ref0_i;
         if (k % 5 == 0) ref1_i = ~ref1_i;
      end
   end

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
      #1;
   endtask

   task automatic hold_len(output int len, output int falls);
      len = 0; falls = 0;
      while (hold_o) begin
         len++;
         if (ref_fall_o) falls++;
         wait_neg(1);
      end
   endtask

   initial begin
      int len, falls;
      wait_neg(4);
      cmp_en = 1;
      @(negedge clk); rst_n = 1;
      wait_neg(6);
      chk("R8 active after warm-up", active_sel_o, 1);
      chk("R8 state after reset", state_o, 0);
      chk("R8 tie after reset", tie_en_o, 1);
      chk("R8 hold after reset", hold_o, 0);

      // clean switch to reference 0, compensation wanted
      @(negedge clk); sel_i = 0;
      wait_neg(2);
      chk("R3 still normal before third edge", hold_o, 0);
      wait_neg(1);
      chk("R3 hold after third edge", hold_o, 1);
      chk("R3 tie cleared", tie_en_o, 0);
      chk("R3 active unchanged", active_sel_o, 1);
      hold_len(len, falls);
      chk("R4 holdover length", len, ST);
      chk("R2 no strobe in holdover", falls, 0);
      chk("R4 committed ref0", active_sel_o, 0);
      chk("R6 tie re-enabled", tie_en_o, 1);

      // switch to reference 1 with compensation left off; tie_ctl wiggles
      @(negedge clk); sel_i = 1; tie_ctl_i = 0;
      wait_neg(4);
      tie_ctl_i = 1;
      wait_neg(2);
      chk("R7 tie low despite control", tie_en_o, 0);
      tie_ctl_i = 0;
      hold_len(len, falls);
      chk("R4 committed ref1", active_sel_o, 1);
      chk("R6 tie left off", tie_en_o, 0);

      // glitch: toggle away and back during holdover
      @(negedge clk); sel_i = 0; tie_ctl_i = 1;
      wait_neg(6);
      chk("R5 in holdover before glitch back", hold_o, 1);
      sel_i = 1;
      wait_neg(3);
      chk("R5 still holding after restart", hold_o, 1);
      chk("R5 active kept", active_sel_o, 1);
      hold_len(len, falls);
      chk("R5 window restarted", (len > ST - 6) ? 1 : 0, 1);
      chk("R5 final active", active_sel_o, 1);
      chk("R6 tie back on", tie_en_o, 1);

      // quiet normal operation with strobes
      wait_neg(40);
      chk("R9 normal at end", hold_o, 0);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule